// File: doc/BRIEF.md
# Binary Code Modulation Shift-Register Driver

This block drives a chain of serial-in, parallel-out shift registers so that every output of the chain is brightness-modulated at the same time by binary code modulation. A frame is made of one period per bit plane, and the planes run from least to most significant. Each period holds a data cycle, whose length grows with the weight of the plane, and a short reset cycle of fixed length. The block reads one output-wide word per plane from an external plane memory, using a plane address it drives itself. It shifts that word out on a serial clock and data pair, with the clock idle low and data sampled on the rising edge. It then latches the word into the register outputs with a strobe and clears them again with a brief clear pulse at the start of the reset cycle. A one-cycle trigger for an external converter fires once per frame, a fixed lead before the end of the data cycle of the most significant plane.

The sequence runs from one counter and a two-state machine. In state `PH_DATA` the counter runs through the data cycle of the current plane. The transition `data_done` leads to `PH_RESET` and advances the plane index. In `PH_RESET` the counter runs the fixed reset cycle. The transition `reset_done` returns to `PH_DATA` and loads the next plane's period into a shadow register, so a new length only ever takes effect at a rollover. Every output is registered: after the k-th rising clock edge following reset release, the outputs show sequence position k-1, where position 0 is count 0 of plane 0's data cycle.

Top module: `bcm_sr_driver`

## Requirements
- R1: While reset is held, `ser_clk`, `ser_data`, `latch`, `blank` and `conv_trig` are low and `plane_addr` is 0. After release, the sequence starts with count 0 of the data cycle of plane 0.
- R2: The data cycle of plane i lasts BASE_LEN + off(i) clocks, with BASE_LEN = 240. The offset off(i) is 1, 3, 9, 29 or 71 for i = 0 to 4, and STEP_UNIT shifted left by i for i of 5 or more (STEP_UNIT defaults to 40). Every reset cycle lasts 80 clocks. A period length takes effect only when the counter rolls over.
- R3: The planes run in the order 0, 1, ..., NUM_PLANES-1 (default 14) and then wrap back to 0 without a gap.
- R4: At data-cycle count c below 64, `ser_clk` equals bit 0 of c and `ser_data` carries word bit 31 - c/2. The word therefore leaves MSB first, bits 31..16 and then bits 15..0, and `ser_data` never changes on a rising `ser_clk`. At every other position both lines are low.
- R5: `latch` is high from data-cycle count 240 to the last count of that data cycle, and low at all other positions.
- R6: `blank` is high for reset-cycle counts 0 and 1 only. It rises in the same output cycle in which `latch` falls.
- R7: `conv_trig` is high for exactly one position per frame: data-cycle count L-300 of the last plane, where L is that plane's data-cycle length.
- R8: The plane word is taken from `plane_data` at data-cycle count 0. A change to the memory after that point affects only the next time that plane is played.
- R9: `plane_addr` holds the index of the plane whose data cycle is running. It moves to the next plane at the end of the data cycle, so it already shows the upcoming plane during the reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| plane_addr | output | AW ($clog2(NUM_PLANES)) | Plane memory read address |
| plane_data | input | NUM_OUT (32) | Plane word read at plane_addr |
| ser_clk | output | 1 | Shift clock, idle low |
| ser_data | output | 1 | Shift data, MSB first |
| latch | output | 1 | Register latch strobe |
| blank | output | 1 | Register clear pulse |
| conv_trig | output | 1 | One-cycle converter trigger |

## Verification
Every output sits behind exactly one register. The result for sequence position p is therefore due after rising edge p+1 counted from reset release, and the plane address for position p+1 is also visible at that point. The bench computes the full per-position output vector for two frames from the length table and the plane words. It then compares one queued item per clock at the falling edge after each rising edge, so each comparison lands half a cycle after the register updates. The memory word of the last plane is changed when the trigger is seen, inside that plane's data cycle and well after its capture. The expected stream therefore carries the old word in frame 0 and the new word in frame 1.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

    typedef enum logic {
        PH_DATA  = 1'b0,
        PH_RESET = 1'b1
    } phase_e;

    // Tuned offsets for the short planes, binary weights above them.
    function automatic int unsigned plane_offset(input int unsigned idx,
                                                 input int unsigned unit);
        case (idx)
            0:       plane_offset = 1;
            1:       plane_offset = 3;
            2:       plane_offset = 9;
            3:       plane_offset = 29;
            4:       plane_offset = 71;
            default: plane_offset = unit << idx;
        endcase
    endfunction

endpackage

// File: rtl/bcm_sequencer.sv
module bcm_sequencer
    import bcm_pkg::*;
#(
    parameter int unsigned NUM_PLANES = 14,
    parameter int unsigned AW         = 4,
    parameter int unsigned CW         = 19,
    parameter int unsigned BASE_LEN   = 240,
    parameter int unsigned STEP_UNIT  = 40,
    parameter int unsigned RESET_LEN  = 80
) (
    input  logic          clk,
    input  logic          rst_n,
    output phase_e        phase,
    output logic [CW-1:0] count,
    output logic [CW-1:0] period,
    output logic [AW-1:0] plane
);

    localparam logic [CW-1:0] RESET_LAST = CW'(RESET_LEN - 1);
    localparam logic [CW-1:0] FIRST_LEN  = CW'(BASE_LEN + plane_offset(0, STEP_UNIT));
    localparam logic [AW-1:0] LAST_PLANE = AW'(NUM_PLANES - 1);

    phase_e        phase_q, phase_d;
    logic [CW-1:0] count_q, count_d;
    logic [CW-1:0] period_q, period_d;
    logic [AW-1:0] plane_q, plane_d;
    logic [CW-1:0] last_cnt;
    logic          roll;

    always_comb begin
        last_cnt = (phase_q == PH_DATA) ? (period_q - CW'(1)) : RESET_LAST;
        roll     = (count_q == last_cnt);
        phase_d  = phase_q;
        plane_d  = plane_q;
        period_d = period_q;
        count_d  = roll ? '0 : count_q + CW'(1);
        unique case (phase_q)
            PH_DATA: begin
                if (roll) begin      // data_done
                    phase_d = PH_RESET;
                    plane_d = (plane_q == LAST_PLANE) ? '0 : plane_q + AW'(1);
                end
            end
            PH_RESET: begin
                if (roll) begin      // reset_done
                    phase_d  = PH_DATA;
                    period_d = CW'(BASE_LEN + plane_offset(int'(plane_q), STEP_UNIT));
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= PH_DATA;
            count_q  <= '0;
            period_q <= FIRST_LEN;
            plane_q  <= '0;
        end else begin
            phase_q  <= phase_d;
            count_q  <= count_d;
            period_q <= period_d;
            plane_q  <= plane_d;
        end
    end

    assign phase  = phase_q;
    assign count  = count_q;
    assign period = period_q;
    assign plane  = plane_q;

    a_r3_plane_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        plane_q <= LAST_PLANE);

    a_r3_plane_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(plane_q) |-> (plane_q == $past(plane_q) + AW'(1) || plane_q == '0));

    a_r2_reset_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RESET) |-> (count_q <= RESET_LAST));

    a_r2_period_at_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA && count_q != '0) |-> $stable(period_q));

endmodule

// File: rtl/bcm_shifter.sv
module bcm_shifter
    import bcm_pkg::*;
#(
    parameter int unsigned NUM_OUT = 32,
    parameter int unsigned CW      = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  phase_e             phase,
    input  logic [CW-1:0]      count,
    input  logic [NUM_OUT-1:0] word,
    output logic               ser_clk,
    output logic               ser_data
);

    localparam logic [CW-1:0] SHIFT_CLKS = CW'(2 * NUM_OUT);

    logic [NUM_OUT-1:0] sreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q   <= '0;
            ser_clk  <= 1'b0;
            ser_data <= 1'b0;
        end else if (phase == PH_DATA && count < SHIFT_CLKS) begin
            if (count == '0) begin
                sreg_q   <= word << 1;
                ser_data <= word[NUM_OUT-1];
                ser_clk  <= 1'b0;
            end else if (count[0]) begin
                ser_clk  <= 1'b1;
            end else begin
                ser_clk  <= 1'b0;
                ser_data <= sreg_q[NUM_OUT-1];
                sreg_q   <= sreg_q << 1;
            end
        end else begin
            ser_clk  <= 1'b0;
            ser_data <= 1'b0;
        end
    end

    a_r4_data_stable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_data));

    a_r4_clock_low_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RESET && count != '0) |-> !ser_clk);

endmodule

// File: rtl/bcm_pulse_gen.sv
module bcm_pulse_gen
    import bcm_pkg::*;
#(
    parameter int unsigned NUM_PLANES = 14,
    parameter int unsigned AW         = 4,
    parameter int unsigned CW         = 19,
    parameter int unsigned BASE_LEN   = 240,
    parameter int unsigned CLEAR_LEN  = 2,
    parameter int unsigned TRIG_LEAD  = 300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] period,
    input  logic [AW-1:0] plane,
    output logic          latch,
    output logic          blank,
    output logic          conv_trig
);

    localparam logic [CW-1:0] LATCH_AT   = CW'(BASE_LEN);
    localparam logic [CW-1:0] CLEAR_END  = CW'(CLEAR_LEN);
    localparam logic [CW-1:0] LEAD       = CW'(TRIG_LEAD);
    localparam logic [AW-1:0] LAST_PLANE = AW'(NUM_PLANES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch     <= 1'b0;
            blank     <= 1'b0;
            conv_trig <= 1'b0;
        end else begin
            latch     <= (phase == PH_DATA)  && (count >= LATCH_AT);
            blank     <= (phase == PH_RESET) && (count < CLEAR_END);
            conv_trig <= (phase == PH_DATA)  && (plane == LAST_PLANE)
                         && (count == period - LEAD);
        end
    end

    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(latch && blank));

    a_r6_clear_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch) |-> blank);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_trig |=> !conv_trig);

endmodule

// File: rtl/bcm_sr_driver.sv
module bcm_sr_driver
    import bcm_pkg::*;
#(
    parameter int unsigned NUM_OUT    = 32,
    parameter int unsigned NUM_PLANES = 14,
    parameter int unsigned BASE_LEN   = 240,
    parameter int unsigned STEP_UNIT  = 40,
    parameter int unsigned RESET_LEN  = 80,
    parameter int unsigned CLEAR_LEN  = 2,
    parameter int unsigned TRIG_LEAD  = 300,
    localparam int unsigned AW        = $clog2(NUM_PLANES),
    localparam int unsigned MAX_LEN   = BASE_LEN + plane_offset(NUM_PLANES - 1, STEP_UNIT),
    localparam int unsigned CW        = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [AW-1:0]      plane_addr,
    input  logic [NUM_OUT-1:0] plane_data,
    output logic               ser_clk,
    output logic               ser_data,
    output logic               latch,
    output logic               blank,
    output logic               conv_trig
);

    phase_e        phase;
    logic [CW-1:0] count;
    logic [CW-1:0] period;
    logic [AW-1:0] plane;

    bcm_sequencer #(
        .NUM_PLANES(NUM_PLANES), .AW(AW), .CW(CW), .BASE_LEN(BASE_LEN),
        .STEP_UNIT(STEP_UNIT), .RESET_LEN(RESET_LEN)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .phase(phase), .count(count),
        .period(period), .plane(plane)
    );

    bcm_shifter #(.NUM_OUT(NUM_OUT), .CW(CW)) u_shift (
        .clk(clk), .rst_n(rst_n), .phase(phase), .count(count),
        .word(plane_data), .ser_clk(ser_clk), .ser_data(ser_data)
    );

    bcm_pulse_gen #(
        .NUM_PLANES(NUM_PLANES), .AW(AW), .CW(CW), .BASE_LEN(BASE_LEN),
        .CLEAR_LEN(CLEAR_LEN), .TRIG_LEAD(TRIG_LEAD)
    ) u_pulse (
        .clk(clk), .rst_n(rst_n), .phase(phase), .count(count),
        .period(period), .plane(plane), .latch(latch), .blank(blank),
        .conv_trig(conv_trig)
    );

    assign plane_addr = plane;

    a_r5_no_shift_while_latched: assert property (@(posedge clk) disable iff (!rst_n)
        latch |-> !ser_clk);

    a_r9_addr_held_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> $stable(plane_addr));

endmodule

// File: tb/sim_bcm_sr_driver.sv
module sim_bcm_sr_driver;

    localparam int unsigned NP    = 14;
    localparam int unsigned BASE  = 240;
    localparam int unsigned UNIT  = 1;
    localparam int unsigned RLEN  = 80;
    localparam int unsigned LEAD  = 300;
    localparam int unsigned AWB   = $clog2(NP);

    typedef struct packed {
        logic [AWB-1:0] addr;
        logic           sck;
        logic           sdo;
        logic           stb;
        logic           clr;
        logic           trg;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AWB-1:0]  plane_addr;
    logic [31:0]     plane_data;
    logic            ser_clk, ser_data, latch, blank, conv_trig;
    logic [31:0]     mem [NP];

    item_t           expq[$];
    int              n_checks = 0;
    int              n_fail = 0;
    int              trig_seen = 0;
    bit              done = 1'b0;
    bit              reported = 1'b0;

    always #5 clk = ~clk;

    assign plane_data = mem[plane_addr];

    bcm_sr_driver #(.STEP_UNIT(UNIT)) u0 (
        .clk(clk), .rst_n(rst_n), .plane_addr(plane_addr), .plane_data(plane_data),
        .ser_clk(ser_clk), .ser_data(ser_data), .latch(latch), .blank(blank),
        .conv_trig(conv_trig)
    );

    function automatic logic [31:0] pattern(input int p);
        case (p)
            0:       pattern = 32'h0000_0000;
            1:       pattern = 32'hFFFF_FFFF;
            2:       pattern = 32'hAAAA_5555;
            3:       pattern = 32'h8000_0001;
            default: pattern = (p * 32'h9E37_79B1) ^ (32'(p) << 20);
        endcase
    endfunction

    function automatic int data_len(input int p);
        int off;
        if (p == 0) off = 1;
        else if (p == 1) off = 3;
        else if (p == 2) off = 9;
        else if (p == 3) off = 29;
        else if (p == 4) off = 71;
        else off = UNIT << p;
        return BASE + off;
    endfunction

    // Driver: expected per-position outputs for one frame (R2, R3, R4..R9).
    task automatic push_frame(input int fr);
        for (int p = 0; p < NP; p++) begin
            int L = data_len(p);
            int np = (p == NP - 1) ? 0 : p + 1;
            logic [31:0] w = (fr == 1 && p == NP - 1) ? ~pattern(p) : pattern(p); // R8
            for (int c = 0; c < L; c++) begin
                item_t it;
                it.addr = (c == L - 1) ? AWB'(np) : AWB'(p);
                it.sck  = (c < 64) ? c[0] : 1'b0;
                it.sdo  = (c < 64) ? w[31 - c / 2] : 1'b0;
                it.stb  = (c >= BASE);
                it.clr  = 1'b0;
                it.trg  = (p == NP - 1) && (c == L - LEAD);
                expq.push_back(it);
            end
            for (int c = 0; c < RLEN; c++) begin
                item_t it;
                it.addr = AWB'(np);
                it.sck  = 1'b0;
                it.sdo  = 1'b0;
                it.stb  = 1'b0;
                it.clr  = (c < 2);
                it.trg  = 1'b0;
                expq.push_back(it);
            end
        end
    endtask

    function automatic string req_of(input item_t d);
        if (d.addr != '0) return "R9";
        if (d.sck || d.sdo) return "R4";
        if (d.stb) return "R5";
        if (d.clr) return "R6";
        return "R7";
    endfunction

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int p = 0; p < NP; p++) mem[p] = pattern(p);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        n_checks++;
        if ({ser_clk, ser_data, latch, blank, conv_trig} !== 5'b0 || plane_addr !== '0) begin
            n_fail++;
            $display("FAIL R1 reset state: got %b addr %0d expected 00000 addr 0",
                     {ser_clk, ser_data, latch, blank, conv_trig}, plane_addr);
        end
        push_frame(0);
        push_frame(1);
        rst_n = 1'b1;
    end

    // Monitor: one queued item per clock, sampled at the falling edge.
    initial begin
        int pos = 0;
        wait (rst_n === 1'b1);
        while (expq.size() > 0) begin
            item_t e, a;
            @(posedge clk);
            @(negedge clk);
            e = expq.pop_front();
            a.addr = plane_addr;
            a.sck  = ser_clk;
            a.sdo  = ser_data;
            a.stb  = latch;
            a.clr  = blank;
            a.trg  = conv_trig;
            n_checks++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s (R2 R3 timing) at position %0d: got %h expected %h",
                         req_of(a ^ e), pos, a, e);
            end
            if (conv_trig === 1'b1) begin
                trig_seen++;
                mem[NP - 1] = ~pattern(NP - 1); // R8: change after capture
            end
            pos++;
        end
        n_checks++;
        if (trig_seen != 2) begin
            n_fail++;
            $display("FAIL R7 trigger count: got %0d expected 2", trig_seen);
        end
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

endmodule